// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

A single-clock static memory macro whose commands (select, global write enable, per-byte write enables and address) are registered on the rising clock edge. Read results come out of an output register one edge after the command edge. Write data trails its command by one cycle. A write is not placed in the array when its data arrives. It is parked in a holding buffer and committed only when the next accepted write reaches the data phase. A read whose address equals the parked address takes the enabled bytes from the buffer and the other bytes from the array, so software always sees the newest value.

The data bus is split into a data-in port and a data-out port, with a drive flag that marks when the output would be driven. The drive flag drops on deselected cycles, on write cycles, while the synchronous sleep input holds the macro dormant, and immediately when the asynchronous output enable goes low. Sleep keeps the stored contents. After sleep ends, a programmable number of edges pass before the macro accepts commands again.

Top module: `lw_sram`

## Requirements
- R1: After reset, `rdata_drv` is low and `rdata` reads zero.
- R2: A read is accepted on an edge where `sel` is 1, `wr_en` is 0, `sleep` is 0 and the macro is not dormant. Its word appears on `rdata`, with `rdata_drv` high, after the following edge.
- R3: For a write accepted on edge n, `wdata` is sampled on edge n+1. Whatever sits on `wdata` on edge n is ignored.
- R4: A parked write is committed to the array by the next accepted write. Reads of several addresses written in sequence each return their own data, whether that data is held in the array or in the buffer.
- R5: A read of the parked address returns buffer bytes for the byte lanes enabled in that write and array bytes for the other lanes.
- R6: `byte_en` has no effect when `wr_en` is 0. Such a cycle is a read and changes no stored byte.
- R7: A cycle with `sel` at 0 performs no access, even if `wr_en` and `byte_en` are set. `rdata_drv` is low after the following edge.
- R8: A write cycle never drives the output: `rdata_drv` is low after the edge that follows a write command.
- R9: While `sleep` is sampled high, and for the first `WAKE_CYC` edges (default 4) on which it is sampled low afterwards, commands are ignored and `rdata_drv` stays low. Stored contents, including a write whose data phase falls on the sleep edge, are kept.
- R10: `out_en` low forces `rdata_drv` low and `rdata` to zero in the same cycle, without waiting for a clock edge.
- R11: A read issued on the edge right after a write to the same address returns the new data.
- R12: Byte lane i occupies bits [9i+8:9i] of `wdata` and `rdata` and is enabled by `byte_en[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Synchronous select; 0 means no access this cycle |
| wr_en | input | 1 | Global write enable; 1 = write, 0 = read |
| byte_en | input | NB (2) | Per-lane write enables, used only when wr_en is 1 |
| addr | input | AW (8) | Word address |
| wdata | input | NB*BW (18) | Write data, one cycle after its command |
| sleep | input | 1 | Synchronous sleep request |
| out_en | input | 1 | Asynchronous output enable |
| rdata | output | NB*BW (18) | Read data; zero when not driven |
| rdata_drv | output | 1 | High when the output bus would be driven |

## Verification
Single isolated writes followed by a read separate a correct latency from an off-by-one, both in the read pipeline and in the data phase of the write. A chain of three writes to distinct addresses, read back in order, shows whether the parked write is committed and whether the newest write is bypassed. A full-word write followed by a one-lane write to the same address shows whether the merge is done per lane. Reads issued during sleep and the wake window, together with deselected cycles that carry write enables, show that ignored commands leave both the contents and the drive flag untouched.

// File: rtl/lw_sram_pkg.sv
// Shared types for the late-write SRAM macro.
// Assumes: a single clock domain; every stage decodes the same operation codes.
package lw_sram_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } lw_op_e;
endpackage

// File: rtl/lw_sram_ctrl.sv
// Command stage: registers the accepted operation, address and lane enables,
// and runs the sleep/wake counter that blocks command acceptance.
// Assumes: WAKE_CYC >= 1.
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int AW       = 8,
    parameter int NB       = 2,
    parameter int WAKE_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_en,
    input  logic [NB-1:0] byte_en,
    input  logic [AW-1:0] addr,
    input  logic          sleep,
    output lw_op_e        s1_op,
    output logic [AW-1:0] s1_addr,
    output logic [NB-1:0] s1_be,
    output logic          dormant
);
    localparam int WCW = $clog2(WAKE_CYC + 1);

    logic [WCW-1:0] wake_cnt;
    logic           accept;

    // Commands are taken only when awake and past the recovery window.
    assign dormant = (wake_cnt != '0);
    assign accept  = !sleep && !dormant;

    // Capture the command of this edge into the first pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_NONE;
            s1_addr <= '0;
            s1_be   <= '0;
        end else begin
            if (accept && sel) begin
                s1_op <= wr_en ? OP_WRITE : OP_READ;
            end else begin
                s1_op <= OP_NONE;
            end
            s1_addr <= addr;
            s1_be   <= wr_en ? byte_en : '0;
        end
    end

    // Sleep reloads the recovery counter; it counts down once sleep drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_cnt <= '0;
        end else if (sleep) begin
            wake_cnt <= WCW'(WAKE_CYC);
        end else if (dormant) begin
            wake_cnt <= wake_cnt - WCW'(1);
        end
    end
endmodule

// File: rtl/lw_sram_wbuf.sv
// Late-write holding buffer: parks the newest write, releases the previous
// one for commit, and merges parked lanes into read data on an address match.
// Assumes: wdata belongs to the write held in the first stage.
module lw_sram_wbuf
    import lw_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lw_op_e           s1_op,
    input  logic [AW-1:0]    s1_addr,
    input  logic [NB-1:0]    s1_be,
    input  logic [NB*BW-1:0] wdata,
    input  logic [NB*BW-1:0] arr_word,
    output logic             cm_en,
    output logic [NB-1:0]    cm_be,
    output logic [AW-1:0]    cm_addr,
    output logic [NB*BW-1:0] cm_data,
    output logic [NB*BW-1:0] rd_word
);
    localparam int DW = NB * BW;

    logic          pend_vld;
    logic [AW-1:0] pend_addr;
    logic [NB-1:0] pend_be;
    logic [DW-1:0] pend_data;
    logic          hit;

    // A write reaching its data phase pushes the parked write into the array.
    assign cm_en   = (s1_op == OP_WRITE) && pend_vld;
    assign cm_be   = pend_be;
    assign cm_addr = pend_addr;
    assign cm_data = pend_data;
    assign hit     = pend_vld && (pend_addr == s1_addr);

    // Park the write whose data arrives on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_be   <= '0;
            pend_data <= '0;
        end else if (s1_op == OP_WRITE) begin
            pend_vld  <= 1'b1;
            pend_addr <= s1_addr;
            pend_be   <= s1_be;
            pend_data <= wdata;
        end
    end

    // Per-lane bypass: parked lanes override array lanes on a match.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_comb begin
            if (hit && pend_be[b]) begin
                rd_word[b*BW +: BW] = pend_data[b*BW +: BW];
            end else begin
                rd_word[b*BW +: BW] = arr_word[b*BW +: BW];
            end
        end
    end
endmodule

// File: rtl/lw_sram_array.sv
// Storage array, one register bank per byte lane, with a lane-masked
// synchronous write port and a combinational read port.
// Assumes: contents are not reset; reads of unwritten words are undefined.
module lw_sram_array #(
    parameter int AW = 8,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [NB-1:0]    wbe,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*BW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*BW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [BW-1:0] mem [DEPTH];

        // Write only the enabled lane of the committed word.
        always_ff @(posedge clk) begin
            if (we && wbe[b]) begin
                mem[waddr] <= wdata[b*BW +: BW];
            end
        end

        assign rdata[b*BW +: BW] = mem[raddr];
    end
endmodule

// File: rtl/lw_sram.sv
// Top of the late-write pipelined SRAM: command stage, holding buffer,
// array and output register, with sleep and asynchronous output gating.
// Assumes: one clock; rst_n is synchronous and active low.
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int AW       = 8,
    parameter int NB       = 2,
    parameter int BW       = 9,
    parameter int WAKE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr_en,
    input  logic [NB-1:0]    byte_en,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    input  logic             sleep,
    input  logic             out_en,
    output logic [NB*BW-1:0] rdata,
    output logic             rdata_drv
);
    localparam int DW = NB * BW;

    lw_op_e        s1_op;
    logic [AW-1:0] s1_addr;
    logic [NB-1:0] s1_be;
    logic          dormant;
    logic          cm_en;
    logic [NB-1:0] cm_be;
    logic [AW-1:0] cm_addr;
    logic [DW-1:0] cm_data;
    logic [DW-1:0] arr_word;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] rd_q;
    logic          drv_q;

    lw_sram_ctrl #(.AW(AW), .NB(NB), .WAKE_CYC(WAKE_CYC)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (wr_en),
        .byte_en (byte_en),
        .addr    (addr),
        .sleep   (sleep),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .s1_be   (s1_be),
        .dormant (dormant)
    );

    lw_sram_wbuf #(.AW(AW), .NB(NB), .BW(BW)) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_op    (s1_op),
        .s1_addr  (s1_addr),
        .s1_be    (s1_be),
        .wdata    (wdata),
        .arr_word (arr_word),
        .cm_en    (cm_en),
        .cm_be    (cm_be),
        .cm_addr  (cm_addr),
        .cm_data  (cm_data),
        .rd_word  (rd_word)
    );

    lw_sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
        .clk   (clk),
        .we    (cm_en),
        .wbe   (cm_be),
        .waddr (cm_addr),
        .wdata (cm_data),
        .raddr (s1_addr),
        .rdata (arr_word)
    );

    // Output register: loads merged read data, flags a driven cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            drv_q <= 1'b0;
        end else begin
            drv_q <= (s1_op == OP_READ);
            if (s1_op == OP_READ) begin
                rd_q <= rd_word;
            end
        end
    end

    // Asynchronous output gating by the enable and the sleep state.
    assign rdata_drv = drv_q && out_en && !dormant;
    assign rdata     = rdata_drv ? rd_q : '0;
endmodule

// File: rtl/lw_sram_chk.sv
// Protocol checker for lw_sram, attached to every instance by bind.
// Assumes: observes the top ports plus the output-register and sleep flags.
module lw_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic wr_en,
    input logic sleep,
    input logic out_en,
    input logic rdata_drv,
    input logic drv_q,
    input logic dormant
);
    AST_READ_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_en && !sleep && !dormant) |=> ##1 drv_q); // R2

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ##1 !drv_q); // R7

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en) |=> ##1 !drv_q); // R8

    AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> dormant); // R9

    AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep || dormant) |=> ##1 !drv_q); // R9

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !rdata_drv); // R10
endmodule

bind lw_sram lw_sram_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr_en     (wr_en),
    .sleep     (sleep),
    .out_en    (out_en),
    .rdata_drv (rdata_drv),
    .drv_q     (drv_q),
    .dormant   (dormant)
);

// File: tb/tb_lw_sram.sv
module tb_lw_sram;
    localparam int AW   = 8;
    localparam int NB   = 2;
    localparam int BW   = 9;
    localparam int DW   = NB * BW;
    localparam int WAKE = 4;
    localparam logic [DW-1:0] JUNK = 18'h2AAAA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [NB-1:0] byte_en = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          sleep = 1'b0;
    logic          out_en = 1'b1;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] ref_mem [1 << AW];
    logic [DW-1:0] carry = JUNK;

    always #10 clk = ~clk;

    lw_sram #(.AW(AW), .NB(NB), .BW(BW), .WAKE_CYC(WAKE)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .byte_en(byte_en),
        .addr(addr), .wdata(wdata), .sleep(sleep), .out_en(out_en),
        .rdata(rdata), .rdata_drv(rdata_drv)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock cycle; wdata carries the data of the previous write.
    task automatic cyc(input logic s, input logic w, input logic [NB-1:0] be, input logic [AW-1:0] a);
        sel = s; wr_en = w; byte_en = be; addr = a; wdata = carry;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [DW-1:0] d);
        for (int b = 0; b < NB; b++)
            if (be[b]) ref_mem[a][b*BW +: BW] = d[b*BW +: BW];
        cyc(1'b1, 1'b1, be, a);
        carry = d;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        cyc(1'b1, 1'b0, '1, a);
        carry = JUNK;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, '0, '0);
        carry = JUNK;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string req);
        rd(a);
        idle();
        check({req, " drv"}, DW'(rdata_drv), DW'(1));
        check({req, " data"}, rdata, ref_mem[a]);
    endtask

    task automatic t_reset();
        check("R1 drv", DW'(rdata_drv), '0);
        check("R1 data", rdata, '0);
    endtask

    task automatic t_basic();
        wr(8'd5, 2'b11, 18'h1B2C3);
        idle();
        check("R8 drv after write", DW'(rdata_drv), '0);
        rd_chk(8'd5, "R2 R3 R12");
        wr(8'd6, 2'b11, 18'h0F0F0);
        rd_chk(8'd6, "R11");
    endtask

    task automatic t_chain();
        wr(8'd10, 2'b11, 18'h11111);
        wr(8'd11, 2'b11, 18'h22222);
        wr(8'd12, 2'b11, 18'h33333);
        rd_chk(8'd10, "R4 array");
        rd_chk(8'd11, "R4 array2");
        rd_chk(8'd12, "R4 bypass");
    endtask

    task automatic t_merge();
        wr(8'd20, 2'b11, 18'h3FE01);
        wr(8'd20, 2'b01, 18'h000AA);
        rd_chk(8'd20, "R5 R12 low lane");
        wr(8'd20, 2'b10, 18'h15400);
        wr(8'd21, 2'b11, 18'h00001);
        rd_chk(8'd20, "R5 committed high lane");
    endtask

    task automatic t_no_be();
        cyc(1'b1, 1'b0, 2'b11, 8'd20);
        carry = 18'h0DEAD;
        idle();
        check("R6 read drives", DW'(rdata_drv), DW'(1));
        rd_chk(8'd20, "R6 unchanged");
    endtask

    task automatic t_desel();
        idle();
        cyc(1'b0, 1'b1, 2'b11, 8'd20);
        carry = 18'h15555;
        idle();
        check("R7 drv low", DW'(rdata_drv), '0);
        rd_chk(8'd20, "R7 unchanged");
    endtask

    task automatic t_sleep();
        wr(8'd30, 2'b11, 18'h2468A);
        sleep = 1'b1;
        cyc(1'b1, 1'b1, 2'b11, 8'd30);
        carry = 18'h00BAD;
        check("R9 drv asleep", DW'(rdata_drv), '0);
        rd(8'd30);
        check("R9 drv asleep2", DW'(rdata_drv), '0);
        sleep = 1'b0;
        for (int i = 0; i < WAKE; i++) begin
            rd(8'd30);
            check("R9 drv waking", DW'(rdata_drv), '0);
        end
        idle();
        check("R9 ignored reads", DW'(rdata_drv), '0);
        rd_chk(8'd30, "R9 kept");
    endtask

    task automatic t_oe();
        rd(8'd5);
        idle();
        out_en = 1'b0;
        #1;
        check("R10 drv off", DW'(rdata_drv), '0);
        check("R10 data off", rdata, '0);
        out_en = 1'b1;
        #1;
        check("R10 drv on", DW'(rdata_drv), DW'(1));
        check("R10 data on", rdata, ref_mem[5]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_chain();
        t_merge();
        t_no_be();
        t_desel();
        t_sleep();
        t_oe();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule